// File: doc/BRIEF.md
# Delay-Window Memory Pattern Checker

This block runs a single pass/fail memory test for one candidate read-strobe delay setting. A calibration controller hands it a 32-bit candidate delay, the memory size in bytes and a small bias, pulses `start`, and later receives a one-cycle `done` pulse with an `error` flag. A sweep is built by running the block once for each candidate value.

The memory is tested in regions of `LINES * LINE_BYTES` bytes. Region bases start at zero and move in steps of one sixty-fourth of the memory size. For each region the block first loads a known-safe setting into the delay register. It then overwrites the region with a fill word and rewrites each word with a pattern derived from its address and the bias. Only after that does it load the candidate setting and read the region back, comparing every word. All accesses go straight to a simple request port with a valid/ready handshake. Read data returns on a separate `mem_rvalid` strobe. The delay register is written through a one-cycle write-enable port.

Top module: `dwin_pattern_check`

## Requirements
- R1: While `rst_n` is low at a clock edge, `busy`, `done`, `error`, `mem_req` and `dly_we` are all 0 after that edge.
- R2: A `start` seen while idle makes `busy` 1 from the next cycle and latches `cand_delay`, `mem_size` and `bias`. A `start` seen while busy is ignored, and so are later changes on those inputs.
- R3: Region bases are 0, S, 2S, ... with S = `mem_size` >> 6. A region at base B is tested only while B + region bytes < `mem_size`. When S is 0, at most the region at base 0 is tested.
- R4: Each region begins with one delay-register write of `SAFE_DLY` (default 32'h0000_7474).
- R5: Next, every word of the region is written with `FILL_WORD` (default 32'h1F1F_1F1F), at byte addresses B + 4i for i = 0 to W-1 in ascending order.
- R6: Then word i is rewritten at the same address with (B + i + `bias`) mod 2^32, in ascending order. The bias is zero-extended.
- R7: After the pattern writes, one delay-register write of the latched candidate follows. The words are then read back in ascending order, with at most one read outstanding: no request is made between an accepted read and its `mem_rvalid`.
- R8: The first read word that differs from its pattern ends the test. `done` pulses with `error` = 1, and no further memory request or delay write is made.
- R9: If every tested word matches, `done` pulses with `error` = 0. `done` lasts one cycle, `busy` falls the cycle after it, and `error` holds its value until the next accepted `start`.
- R10: With `mem_ready` held at 1 and read data returned the cycle after each read is accepted, `done` rises R*(4W+4)+1 cycles after the edge that samples `start`. Here W is the number of words per region and R is the number of regions tested.
- R11: While `mem_req` is 1 and `mem_ready` is 0, the request, its address, data and direction are held unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one test run |
| cand_delay | input | 32 | Candidate delay-register value |
| mem_size | input | 32 | Memory size in bytes |
| bias | input | BIAS_W | Offset added to each pattern word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Result of the last run (1 = mismatch) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| dly_we | output | 1 | Delay-register write strobe |
| dly_wdata | output | 32 | Delay-register write value |

## Verification
`busy` is due one cycle after the edge that takes `start`. Each accepted request takes effect at the edge where `mem_req` and `mem_ready` are both high, and the memory answers a read one cycle later. With no stalls, `done` lands R*(4W+4)+1 edges after the start edge; a window failure on the first read lands it 2W+5 edges after. The bench drives and samples only at the falling edge. It decides `mem_ready` before it looks at `mem_req`, so a transfer is credited to exactly the edge that completes it. It counts falling edges from the start edge and compares the count at `done` with the figure above.

// File: rtl/dwin_pkg.sv
// Package: shared state encoding for the delay-window pattern checker.
// Assumes nothing beyond being compiled before the modules that import it.
package dwin_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,    // waiting for start
        ST_TEST,    // decide whether the current region is tested
        ST_SAFE,    // load the safe delay
        ST_FILL,    // write the fill word over the region
        ST_PAT,     // write the address-derived pattern
        ST_CAND,    // load the candidate delay
        ST_RDREQ,   // issue one read
        ST_RDWAIT,  // wait for its data and compare
        ST_NEXT,    // step to the next region
        ST_DONE     // one-cycle completion
    } dwin_state_e;

endpackage

// File: rtl/dwin_region_walk.sv
// Region walker: holds the current region base, the latched memory size and
// the step (one sixty-fourth of the size). It reports whether the current base
// still leaves a whole region below the end of memory.
// Assumes load and advance are never high in the same cycle.
module dwin_region_walk #(
    parameter int AW           = 32,
    parameter int REGION_BYTES = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic [AW-1:0] mem_size,
    output logic [AW-1:0] base,
    output logic          in_range
);
    localparam int        EW      = AW + 1;
    localparam logic [EW-1:0] REGION_E = EW'(REGION_BYTES);

    logic [AW-1:0] size_q;
    logic [AW-1:0] step_q;
    logic          exhausted;

    // Latch the size and step on load; move the base on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base      <= '0;
            size_q    <= '0;
            step_q    <= '0;
            exhausted <= 1'b0;
        end else if (load) begin
            base      <= '0;
            size_q    <= mem_size;
            step_q    <= mem_size >> 6;
            exhausted <= 1'b0;
        end else if (advance) begin
            if (step_q == '0) exhausted <= 1'b1;
            else              base      <= base + step_q;
        end
    end

    // A region is tested while base + region size stays below the size.
    always_comb begin
        in_range = !exhausted && (({1'b0, base} + REGION_E) < {1'b0, size_q});
    end

endmodule

// File: rtl/dwin_word_walk.sv
// Word walker: index of the current word inside a region. It wraps to zero
// after the last word, so every pass over a region starts at index zero.
// Assumes clear and inc are never high in the same cycle.
module dwin_word_walk #(
    parameter int WORDS = 1024,
    localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          inc,
    output logic [IW-1:0] idx,
    output logic          last
);
    localparam logic [IW-1:0] LAST_IDX = IW'(WORDS - 1);

    // Step the index, wrapping after the last word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) idx <= '0;
        else if (inc)        idx <= last ? '0 : idx + 1'b1;
    end

    // Flag the final word of the region.
    always_comb last = (idx == LAST_IDX);

endmodule

// File: rtl/dwin_pattern.sv
// Pattern generator: byte address of word idx in the region at base, and the
// expected pattern base + idx + bias. Purely combinational.
// Assumes 32-bit words, so word addresses advance by four bytes.
module dwin_pattern #(
    parameter int AW     = 32,
    parameter int IW     = 10,
    parameter int BIAS_W = 8
) (
    input  logic [AW-1:0]     base,
    input  logic [IW-1:0]     idx,
    input  logic [BIAS_W-1:0] bias,
    output logic [AW-1:0]     word_addr,
    output logic [AW-1:0]     pattern
);
    // Form the address and the pattern word from base, index and bias.
    always_comb begin
        word_addr = base + (AW'(idx) << 2);
        pattern   = base + AW'(idx) + AW'(bias);
    end

endmodule

// File: rtl/dwin_pattern_check.sv
// Top: runs one write/readback test of the memory under a candidate delay.
// Each region: safe delay, fill pass, pattern pass, candidate delay, readback.
// Assumes the memory answers each accepted read with exactly one mem_rvalid,
// in a later cycle, and that the delay register takes a write in one cycle.
module dwin_pattern_check #(
    parameter int          LINE_BYTES = 32,
    parameter int          LINES      = 128,
    parameter int          BIAS_W     = 8,
    parameter logic [31:0] SAFE_DLY   = 32'h0000_7474,
    parameter logic [31:0] FILL_WORD  = 32'h1F1F_1F1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       cand_delay,
    input  logic [31:0]       mem_size,
    input  logic [BIAS_W-1:0] bias,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              dly_we,
    output logic [31:0]       dly_wdata
);
    import dwin_pkg::*;

    localparam int AW           = 32;
    localparam int REGION_BYTES = LINE_BYTES * LINES;
    localparam int WORDS        = REGION_BYTES / 4;
    localparam int IW           = (WORDS > 1) ? $clog2(WORDS) : 1;

    dwin_state_e       state, state_nx;
    logic [31:0]       cand_q;
    logic [BIAS_W-1:0] bias_q;
    logic              err_q;
    logic [AW-1:0]     base;
    logic              in_range;
    logic [IW-1:0]     idx;
    logic              last;
    logic [AW-1:0]     word_addr;
    logic [AW-1:0]     pattern;
    logic              accept;
    logic              rd_match;
    logic              wd_inc;
    logic              run_load;

    dwin_region_walk #(.AW(AW), .REGION_BYTES(REGION_BYTES)) u_region (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (run_load),
        .advance  (state == ST_NEXT),
        .mem_size (mem_size),
        .base     (base),
        .in_range (in_range)
    );

    dwin_word_walk #(.WORDS(WORDS)) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == ST_SAFE),
        .inc   (wd_inc),
        .idx   (idx),
        .last  (last)
    );

    dwin_pattern #(.AW(AW), .IW(IW), .BIAS_W(BIAS_W)) u_pat (
        .base      (base),
        .idx       (idx),
        .bias      (bias_q),
        .word_addr (word_addr),
        .pattern   (pattern)
    );

    // Handshake, compare and counter-step terms.
    always_comb begin
        run_load = (state == ST_IDLE) && start;
        accept   = mem_req && mem_ready;
        rd_match = (mem_rdata == pattern);
        wd_inc   = (((state == ST_FILL) || (state == ST_PAT)) && mem_ready)
                 || ((state == ST_RDWAIT) && mem_rvalid && rd_match);
    end

    // Next-state decision for the test sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_TEST;
            ST_TEST:   state_nx = in_range ? ST_SAFE : ST_DONE;
            ST_SAFE:   state_nx = ST_FILL;
            ST_FILL:   if (mem_ready && last) state_nx = ST_PAT;
            ST_PAT:    if (mem_ready && last) state_nx = ST_CAND;
            ST_CAND:   state_nx = ST_RDREQ;
            ST_RDREQ:  if (mem_ready) state_nx = ST_RDWAIT;
            ST_RDWAIT: if (mem_rvalid) begin
                           if (!rd_match) state_nx = ST_DONE;
                           else if (last) state_nx = ST_NEXT;
                           else           state_nx = ST_RDREQ;
                       end
            ST_NEXT:   state_nx = ST_TEST;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register plus the values latched at start and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cand_q <= '0;
            bias_q <= '0;
            err_q  <= 1'b0;
        end else begin
            state <= state_nx;
            if (run_load) begin
                cand_q <= cand_delay;
                bias_q <= bias;
                err_q  <= 1'b0;
            end else if ((state == ST_RDWAIT) && mem_rvalid && !rd_match) begin
                err_q <= 1'b1;
            end
        end
    end

    // Port outputs decoded from the state.
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        error     = err_q;
        mem_req   = (state == ST_FILL) || (state == ST_PAT) || (state == ST_RDREQ);
        mem_we    = (state == ST_FILL) || (state == ST_PAT);
        mem_addr  = word_addr;
        mem_wdata = (state == ST_FILL) ? FILL_WORD :
                    (state == ST_PAT)  ? pattern   : '0;
        dly_we    = (state == ST_SAFE) || (state == ST_CAND);
        dly_wdata = (state == ST_SAFE) ? SAFE_DLY : cand_q;
    end

    // Tracks a read accepted on the port and not yet answered.
    logic rd_pend;
    always_ff @(posedge clk) begin
        if (!rst_n)                   rd_pend <= 1'b0;
        else if (accept && !mem_we)   rd_pend <= 1'b1;
        else if (mem_rvalid)          rd_pend <= 1'b0;
    end

    assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_single_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend |-> !mem_req);

    assert_quiet_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_req && !dly_we));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(mem_wdata) && $stable(mem_we)));

endmodule

// File: tb/dwin_pattern_check_test.sv
// Bench: behavioural memory with a delay window, an expected-event queue
// built from the requirements, and per-cycle comparison at the falling edge.
module dwin_pattern_check_test;

    localparam int LB = 4;
    localparam int LN = 8;
    localparam int W  = LB * LN / 4;
    localparam int RB = LB * LN;
    localparam logic [31:0] SAFE = 32'h0000_7474;
    localparam logic [31:0] FILL = 32'h1F1F_1F1F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cand_delay = '0;
    logic [31:0] mem_size = '0;
    logic [7:0]  bias = '0;
    logic        busy, done, error;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b1;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        dly_we;
    logic [31:0] dly_wdata;

    always #4 clk = ~clk;

    dwin_pattern_check #(.LINE_BYTES(LB), .LINES(LN)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cand_delay(cand_delay),
        .mem_size(mem_size), .bias(bias), .busy(busy), .done(done),
        .error(error), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .dly_we(dly_we),
        .dly_wdata(dly_wdata)
    );

    typedef struct {
        int          kind;   // 0 delay write, 1 memory write, 2 memory read
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } ev_t;

    ev_t         exp_q[$];
    logic [31:0] mem [0:255];
    logic [31:0] dreg = '0;
    int          checks = 0;
    int          errors = 0;
    bit          exp_err;
    int          exp_regions;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit window_bad(input logic [31:0] d);
        return (d[7:4] < 4'd5) || (d[7:4] > 4'd9);
    endfunction

    // Reference sequence of port events for one run.
    task automatic build_expect(input logic [31:0] cand, input logic [31:0] size,
                                input logic [7:0] b, input logic [31:0] bad);
        longint off  = 0;
        longint step = size >> 6;
        exp_q.delete();
        exp_err = 0;
        exp_regions = 0;
        while (off + RB < size) begin
            exp_regions++;
            exp_q.push_back('{0, 32'h0, SAFE, "R4"});
            for (int i = 0; i < W; i++)
                exp_q.push_back('{1, 32'(off + 4*i), FILL, "R5"});
            for (int i = 0; i < W; i++)
                exp_q.push_back('{1, 32'(off + 4*i), 32'(off + i + b), "R6"});
            exp_q.push_back('{0, 32'h0, cand, "R7"});
            for (int i = 0; i < W; i++) begin
                exp_q.push_back('{2, 32'(off + 4*i), 32'h0, "R7"});
                if (window_bad(cand) || (32'(off + 4*i) == bad)) begin
                    exp_err = 1;
                    return;
                end
            end
            if (step == 0) break;
            off += step;
        end
    endtask

    task automatic run_test(input string name, input logic [31:0] cand,
                            input logic [31:0] size, input logic [7:0] b,
                            input logic [31:0] bad, input bit stall,
                            input bit poke, input int exp_cyc);
        bit          rd_pend = 0;
        logic [31:0] rd_addr = '0;
        bit          held = 0;
        logic [31:0] held_addr = '0;
        bit          seen_done = 0;
        int          safe_seen = 0;
        int          j = 0;
        $display("-- %s", name);
        build_expect(cand, size, b, bad);
        @(negedge clk);
        cand_delay = cand; mem_size = size; bias = b; start = 1'b1;
        while (!seen_done) begin
            @(negedge clk);
            j++;
            start = 1'b0;
            if (poke && j == 30) begin
                start = 1'b1; cand_delay = 32'h0000_00F4; mem_size = 32'd32; bias = 8'd0;
            end
            chk(busy == 1'b1, "R2", "busy while running", 32'(busy), 32'd1);
            mem_rvalid = rd_pend;
            if (rd_pend) begin
                mem_rdata = mem[rd_addr[9:2]];
                if (window_bad(dreg)) mem_rdata = mem_rdata ^ 32'h0000_0100;
                if (rd_addr == bad)   mem_rdata = mem_rdata ^ 32'h0000_0001;
                chk(!mem_req, "R7", "request while read outstanding", 32'(mem_req), 32'd0);
            end
            rd_pend = 0;
            if (held)
                chk(mem_req && mem_addr == held_addr, "R11", "stalled request held",
                    mem_addr, held_addr);
            mem_ready = stall ? ((j % 3) != 0) : 1'b1;
            held = mem_req && !mem_ready;
            held_addr = mem_addr;
            if (dly_we) begin
                if (exp_q.size() == 0) chk(0, "R8", "extra delay write", dly_wdata, 32'h0);
                else begin
                    ev_t e = exp_q.pop_front();
                    chk(e.kind == 0 && dly_wdata == e.data, e.tag, "delay write", dly_wdata, e.data);
                    if (e.tag == "R4") safe_seen++;
                end
                dreg = dly_wdata;
            end
            if (mem_req && mem_ready) begin
                if (exp_q.size() == 0) chk(0, "R8", "extra request", mem_addr, 32'h0);
                else begin
                    ev_t e = exp_q.pop_front();
                    chk(e.kind == (mem_we ? 1 : 2) && mem_addr == e.addr, e.tag,
                        "request address", mem_addr, e.addr);
                    if (mem_we) chk(mem_wdata == e.data, e.tag, "write data", mem_wdata, e.data);
                end
                if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
                else begin rd_pend = 1; rd_addr = mem_addr; end
            end
            if (done) begin
                seen_done = 1;
                chk(error == exp_err, exp_err ? "R8" : "R9", "error at done", 32'(error), 32'(exp_err));
                chk(exp_q.size() == 0, "R8", "events left at done", exp_q.size(), 32'd0);
                chk(safe_seen == exp_regions, "R3", "regions tested", safe_seen, exp_regions);
                if (exp_cyc >= 0)
                    chk(j == exp_cyc, "R10", "cycles to done", j, exp_cyc);
            end
            if (j > 20000) begin
                chk(0, "R9", "watchdog expired", j, 32'd0);
                seen_done = 1;
            end
        end
        mem_rvalid = 1'b0;
        mem_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!done && !busy && !mem_req && !dly_we, "R9", "quiet after done",
                {done, busy, mem_req, dly_we}, 32'h0);
            chk(error == exp_err, "R9", "error held", 32'(error), 32'(exp_err));
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + i;
        repeat (3) @(negedge clk);
        chk({busy, done, error, mem_req, dly_we} == 5'b0, "R1", "reset outputs",
            {busy, done, error, mem_req, dly_we}, 32'h0);
        rst_n = 1'b1;
        run_test("pass, 62 regions", 32'h0000_0074, 32'd1024, 8'd3, 32'hFFFF_FFFF, 0, 0, 62*(4*W+4)+2);
        run_test("pass with stalls", 32'h0000_0094, 32'd512, 8'hA5, 32'hFFFF_FFFF, 1, 0, -1);
        run_test("window fail", 32'h0000_00F4, 32'd1024, 8'd1, 32'hFFFF_FFFF, 0, 0, 2*W+6);
        run_test("bad word in region 5", 32'h0000_0064, 32'd1024, 8'd7, 32'd92, 1, 0, -1);
        run_test("memory smaller than region", 32'h0000_0074, 32'd32, 8'd0, 32'hFFFF_FFFF, 0, 0, 2);
        run_test("zero step, one region", 32'h0000_0074, 32'd40, 8'hFF, 32'hFFFF_FFFF, 0, 0, 4*W+6);
        run_test("start while busy", 32'h0000_0084, 32'd256, 8'd9, 32'hFFFF_FFFF, 0, 1, 56*(4*W+4)+2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule